// File: doc/BRIEF.md
# 2x2 Stride-2 Pooling Unit

This block shrinks a streamed feature map by a factor of two in each dimension. Pixels arrive one per valid cycle in row-major order. Each non-overlapping 2x2 window becomes one output pixel. A W by H map gives floor(W/2) by floor(H/2) outputs. A mode bit picks the reduction. Max mode keeps the largest signed element of the window. Average mode sums the four elements and shifts the sum arithmetically right by two, which truncates toward minus infinity.

Elements are signed and either 8 or 16 bits wide. In 8-bit mode only the low byte of the input word is used, and results come out sign-extended to the full output word. Only a single storage row is kept. On even rows the unit combines each pair of horizontal neighbours and parks the result there. On the matching odd row it merges that parked value with the new pair and emits an output pixel. When W or H is odd, the last column or the last row does not form a full window and is discarded. The configuration must stay constant while a frame streams. After the last input pixel of a frame, the next valid pixel starts a new frame.

Top module: `pool2_unit`

## Requirements
- R1: After reset, and after a reset that interrupts a frame, out_valid and out_last are 0 and the next valid pixel is treated as row 0, column 0.
- R2: With cfg_avg = 0 (max mode), each output equals the signed maximum of the four window elements.
- R3: With cfg_avg = 1 (average mode), each output equals the exact signed sum of the four window elements shifted arithmetically right by 2. The sum cannot overflow, including when all four elements are the most negative or the most positive value.
- R4: The output at column c and row l is built from input rows 2l and 2l+1 and input columns 2c and 2c+1. Outputs are emitted in row-major order.
- R5: With cfg_half = 0, each element is in_data[7:0] taken as signed 8-bit, and in_data[15:8] has no effect. Outputs are the 8-bit result sign-extended to 16 bits.
- R6: With cfg_half = 1, each element is in_data[15:0] taken as signed 16-bit.
- R7: A frame yields exactly floor(W/2) * floor(H/2) outputs. An odd last column or an odd last row is dropped.
- R8: out_valid is high for exactly one cycle, in the cycle after the pixel at odd row 2l+1 and odd column 2c+1 is accepted. It is never high at any other time.
- R9: out_last is high together with the final output of a frame and low for every other output.
- R10: After the W*H-th pixel of a frame, the next valid pixel begins a new frame at row 0, column 0, with no reset needed.
- R11: A cycle with in_valid = 0 changes no state and produces no output. Gaps between pixels do not alter the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cols | input | $clog2(MAX_W+1) | Input map width W, 2 to MAX_W |
| cfg_rows | input | $clog2(MAX_H+1) | Input map height H, 2 to MAX_H |
| cfg_half | input | 1 | 1: signed 16-bit elements, 0: signed 8-bit elements |
| cfg_avg | input | 1 | 1: average pooling, 0: max pooling |
| in_valid | input | 1 | Input pixel present this cycle |
| in_data | input | DATA_W | Input pixel |
| out_valid | output | 1 | Output pixel present this cycle |
| out_data | output | DATA_W | Pooled pixel, sign-extended |
| out_last | output | 1 | Marks the final output of a frame |

## Verification
The hardest situation to reach is the interaction of an odd map size with the frame wrap. A dropped last column or row must not leave stale row-buffer contents or a mistimed last flag behind for the next frame. The bench therefore runs frames of every size combination back to back, with no reset between them. It covers both element widths, both modes, and patterns of extreme values that saturate the average sum. Some frames insert idle gaps in the stream. For every output, the bench checks that it follows the exact input pixel that closes its window.

// File: rtl/pool2_pkg.sv
package pool2_pkg;
    // Reduction applied inside each 2x2 window.
    typedef enum logic {
        PM_MAX = 1'b0,
        PM_AVG = 1'b1
    } pool_mode_e;

    // Extra accumulator bits so a sum of four elements never overflows.
    localparam int GUARD_BITS = 2;
endpackage

// File: rtl/pool2_pair_op.sv
module pool2_pair_op
    import pool2_pkg::*;
#(
    parameter int ACC_W = 18
) (
    input  pool_mode_e               mode,
    input  logic signed [ACC_W-1:0]  a,
    input  logic signed [ACC_W-1:0]  b,
    output logic signed [ACC_W-1:0]  y
);
    always_comb begin
        if (mode == PM_AVG) begin
            y = a + b;
        end else begin
            y = (a > b) ? a : b;
        end
    end
endmodule

// File: rtl/pool2_rowbuf.sv
module pool2_rowbuf #(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int ACC_W = 18
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic signed [ACC_W-1:0]  wdata,
    input  logic [AW-1:0]            raddr,
    output logic signed [ACC_W-1:0]  rdata
);
    logic signed [ACC_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pool2_unit.sv
module pool2_unit
    import pool2_pkg::*;
#(
    parameter int MAX_W  = 64,
    parameter int MAX_H  = 64,
    parameter int DATA_W = 16,
    localparam int CW    = $clog2(MAX_W + 1),
    localparam int RW    = $clog2(MAX_H + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     cfg_cols,
    input  logic [RW-1:0]     cfg_rows,
    input  logic              cfg_half,
    input  logic              cfg_avg,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = DATA_W + GUARD_BITS;
    localparam int BUF_D  = MAX_W / 2;
    localparam int BW     = (BUF_D > 1) ? $clog2(BUF_D) : 1;

    typedef struct packed {
        logic [CW-1:0]            col;
        logic [RW-1:0]            row;
        logic signed [ACC_W-1:0]  hold;
        logic                     out_valid;
        logic [DATA_W-1:0]        out_data;
        logic                     out_last;
    } state_t;

    state_t state_d, state_q;

    pool_mode_e              mode_w;
    logic signed [ACC_W-1:0] elem;
    logic signed [ACC_W-1:0] horiz;
    logic signed [ACC_W-1:0] rb_rdata;
    logic signed [ACC_W-1:0] vert;
    logic signed [ACC_W-1:0] res;
    logic [CW-1:0]           usable_cols;
    logic [RW-1:0]           usable_rows;
    logic                    col_in;
    logic                    row_in;
    logic                    rb_we;

    assign mode_w      = cfg_avg ? PM_AVG : PM_MAX;
    assign usable_cols = {cfg_cols[CW-1:1], 1'b0};
    assign usable_rows = {cfg_rows[RW-1:1], 1'b0};
    assign col_in      = state_q.col < usable_cols;
    assign row_in      = state_q.row < usable_rows;

    // Element sign extension selected by element width.
    always_comb begin
        if (cfg_half) begin
            elem = {{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data};
        end else begin
            elem = {{(ACC_W-HALF_W){in_data[HALF_W-1]}}, in_data[HALF_W-1:0]};
        end
    end

    pool2_pair_op #(.ACC_W(ACC_W)) u_horiz (
        .mode (mode_w),
        .a    (state_q.hold),
        .b    (elem),
        .y    (horiz)
    );

    pool2_rowbuf #(.DEPTH(BUF_D), .AW(BW), .ACC_W(ACC_W)) u_rowbuf (
        .clk   (clk),
        .we    (rb_we),
        .waddr (state_q.col[BW:1]),
        .wdata (horiz),
        .raddr (state_q.col[BW:1]),
        .rdata (rb_rdata)
    );

    pool2_pair_op #(.ACC_W(ACC_W)) u_vert (
        .mode (mode_w),
        .a    (rb_rdata),
        .b    (horiz),
        .y    (vert)
    );

    assign res = (mode_w == PM_AVG) ? (vert >>> 2) : vert;

    always_comb begin
        state_d = state_q;
        rb_we   = 1'b0;
        state_d.out_valid = 1'b0;
        state_d.out_last  = 1'b0;
        if (in_valid) begin
            if (col_in && !state_q.col[0]) begin
                state_d.hold = elem;
            end
            rb_we = col_in && row_in && state_q.col[0] && !state_q.row[0];
            state_d.out_valid = col_in && row_in && state_q.col[0] && state_q.row[0];
            if (state_d.out_valid) begin
                state_d.out_data = res[DATA_W-1:0];
            end
            state_d.out_last = state_d.out_valid
                             && (state_q.col == usable_cols - CW'(1))
                             && (state_q.row == usable_rows - RW'(1));
            if (state_q.col == cfg_cols - CW'(1)) begin
                state_d.col = '0;
                if (state_q.row == cfg_rows - RW'(1)) begin
                    state_d.row = '0;
                end else begin
                    state_d.row = state_q.row + RW'(1);
                end
            end else begin
                state_d.col = state_q.col + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.out_valid;
    assign out_data  = state_q.out_data;
    assign out_last  = state_q.out_last;
endmodule

// File: rtl/pool2_unit_chk.sv
module pool2_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_half,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last
);
    localparam int HALF_W = DATA_W / 2;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !out_last));

    // R8
    out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R9
    last_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_last);

    // R5
    byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_half) |->
            ((&out_data[DATA_W-1:HALF_W-1]) || !(|out_data[DATA_W-1:HALF_W-1])));
endmodule

bind pool2_unit pool2_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_half  (cfg_half),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/pool2_unit_tb.sv
`timescale 1ns/1ps
module pool2_unit_tb;
    localparam int MAX_W  = 8;
    localparam int MAX_H  = 8;
    localparam int DATA_W = 16;
    localparam int CW     = $clog2(MAX_W + 1);
    localparam int RW     = $clog2(MAX_H + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     cfg_cols = '0;
    logic [RW-1:0]     cfg_rows = '0;
    logic              cfg_half = 1'b0;
    logic              cfg_avg = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_last;

    always #4 clk = ~clk;

    pool2_unit #(.MAX_W(MAX_W), .MAX_H(MAX_H), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_cols  (cfg_cols),
        .cfg_rows  (cfg_rows),
        .cfg_half  (cfg_half),
        .cfg_avg   (cfg_avg),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int          n_out;
    logic [15:0] got [64];
    logic        got_last [64];
    int          got_src [64];
    int          drv_idx = -1;
    logic [15:0] px [64];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample outputs left by the previous edge, then drive the next input.
    task automatic tick(input bit v, input logic [15:0] d, input int idx);
        @(negedge clk);
        if (out_valid) begin
            if (n_out < 64) begin
                got[n_out]      = out_data;
                got_last[n_out] = out_last;
                got_src[n_out]  = drv_idx;
            end
            n_out++;
        end
        in_valid = v;
        in_data  = d;
        drv_idx  = v ? idx : -1;
    endtask

    function automatic int ev(input logic [15:0] d, input bit half);
        if (half) return int'($signed(d));
        return int'($signed(d[7:0]));
    endfunction

    function automatic logic [15:0] gen(input int i, input int seed, input bit half, input int pat);
        int h;
        logic [7:0] junk;
        junk = 8'(i * 29 + seed);
        if (pat == 1) return half ? 16'h8000 : {junk ^ 8'h5A, 8'h80};
        if (pat == 2) return half ? 16'h7FFF : {junk ^ 8'hC3, 8'h7F};
        h = (i * 7919 + seed * 131) ^ (i << 5) ^ (seed * i * 17);
        return h[15:0];
    endfunction

    task automatic run_frame(input int w, input int h, input bit half, input bit avg,
                             input int pat, input bit gaps);
        int wo, ho;
        cfg_cols = CW'(w);
        cfg_rows = RW'(h);
        cfg_half = half;
        cfg_avg  = avg;
        n_out    = 0;
        for (int i = 0; i < w * h; i++) begin
            if (gaps && (i % 3 == 1)) tick(1'b0, 16'hDEAD, 0);
            px[i] = gen(i, w * 16 + h + pat * 7, half, pat);
            tick(1'b1, px[i], i);
        end
        repeat (3) tick(1'b0, 16'h0, 0);
        wo = w / 2;
        ho = h / 2;
        // R7: dropped odd column/row gives floor(W/2)*floor(H/2) outputs
        chk(n_out == wo * ho, "R7 output count", n_out, wo * ho);
        for (int l = 0; l < ho; l++) begin
            for (int c = 0; c < wo; c++) begin
                int k, a0, a1, a2, a3, sum, mx, exp, act;
                string tag;
                k = l * wo + c;
                if (k >= n_out || k >= 64) continue;
                // R4: window rows 2l,2l+1 and columns 2c,2c+1
                a0 = ev(px[(2*l)*w + 2*c], half);
                a1 = ev(px[(2*l)*w + 2*c + 1], half);
                a2 = ev(px[(2*l+1)*w + 2*c], half);
                a3 = ev(px[(2*l+1)*w + 2*c + 1], half);
                sum = a0 + a1 + a2 + a3;
                mx = a0;
                if (a1 > mx) mx = a1;
                if (a2 > mx) mx = a2;
                if (a3 > mx) mx = a3;
                exp = avg ? (sum >>> 2) : mx;
                act = int'($signed(got[k]));
                tag = $sformatf("%s/%s/R4%s w=%0d h=%0d k=%0d", avg ? "R3" : "R2",
                                half ? "R6" : "R5", gaps ? "/R11" : "", w, h, k);
                chk(act == exp, tag, act, exp);
                chk(got_src[k] == (2*l+1)*w + 2*c + 1, "R8 output timing",
                    got_src[k], (2*l+1)*w + 2*c + 1);
                chk(got_last[k] == (k == wo * ho - 1), "R9 last flag",
                    int'(got_last[k]), int'(k == wo * ho - 1));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        n_out = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(out_valid == 1'b0 && out_last == 1'b0, "R1 reset outputs", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);

        // R1: reset in the middle of a frame returns to row 0, column 0
        cfg_cols = CW'(4);
        cfg_rows = RW'(4);
        for (int i = 0; i < 5; i++) tick(1'b1, 16'(i * 1000 + 3), i);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_last == 1'b0, "R1 mid-frame reset", int'(out_valid), 0);
        rst_n = 1'b1;
        drv_idx = -1;
        run_frame(4, 4, 1'b1, 1'b0, 0, 1'b0);

        // R10: every frame below follows the previous one with no reset
        foreach (px[i]) px[i] = '0;
        for (int wi = 0; wi < 5; wi++) begin
            for (int hi = 0; hi < 3; hi++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int pat = 0; pat < 3; pat++) begin
                        int w, h;
                        w = (wi == 0) ? 2 : (wi == 1) ? 3 : (wi == 2) ? 4 : (wi == 3) ? 5 : 8;
                        h = (hi == 0) ? 2 : (hi == 1) ? 3 : 5;
                        run_frame(w, h, m[0], m[1], pat, 1'((w + h + pat) % 2));
                    end
                end
            end
        end

        // R10: a tiny frame right after a large odd one still starts at (0,0)
        run_frame(7, 7, 1'b0, 1'b1, 0, 1'b0);
        run_frame(2, 2, 1'b0, 1'b0, 0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule